// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a bus master that fetches one 16-bit word from a small serial EEPROM of the 1 Kbit or 2 Kbit class, organised as 16-bit words, over a three-wire link. The link has a chip select, a serial clock and one data line in each direction. A one-cycle pulse on `start_i` starts a read. On that cycle the block takes the word address, the part-size select and the clock divider setting. It then runs the whole pin sequence by itself. The sequence is: raise chip select, send a framing clock, send the read command and the address, clock in the data word, drop chip select, and send a closing clock. When the word is ready, `done_o` pulses.

Every pin setting is held for one phase of `div_i + 1` system clocks, so slow parts can be met from a fast system clock. The serial clock rests low. Each serial clock pulse is one high phase followed by one low phase. Whenever data-out changes to a new bit, a set-up phase comes before the pulse that clocks the bit. The address is 8 bits long for the larger part and 6 bits long for the smaller part.

Top module: `uwire_word_reader`

## Requirements
- R1: While `rst_n` is low, `ee_cs_o`, `ee_sk_o`, `ee_mosi_o` and `done_o` are low and `data_o` is zero. This holds even if reset comes in the middle of a read, and the block then returns to idle.
- R2: Each pin setting lasts `div_i + 1` system clocks, and each high phase of `ee_sk_o` lasts exactly that long. Count from the clock edge that samples `start_i` to the edge that raises `done_o`. This span is (48 + 3·A)·(`div_i` + 1) clocks, where A is the address length.
- R3: After `ee_cs_o` rises, exactly one `ee_sk_o` pulse with `ee_mosi_o` low is sent before the first command bit.
- R4: The command bits 1, 1, 0 are sent in that order. Each bit is placed on `ee_mosi_o` one phase before the rising edge that clocks it.
- R5: The address is sent most significant bit first. With `big_part_i` = 1 it is `addr_i[7:0]` (A = 8). With `big_part_i` = 0 it is `addr_i[5:0]` (A = 6), and `addr_i[7:6]` have no effect.
- R6: After the address, the data phase has 16 `ee_sk_o` pulses, and `ee_mosi_o` is low at every one of them.
- R7: `ee_miso_i` is sampled at the end of the low phase that follows each data-phase pulse. The k-th sample (k = 0..15) lands in `data_o[15-k]`, so the part's leading dummy zero is never captured.
- R8: After the last data sample, `ee_cs_o` falls first. Then exactly one more `ee_sk_o` pulse is sent with `ee_cs_o` low, before `done_o`.
- R9: `done_o` is high for exactly one clock. `data_o` then holds the word unchanged until the next accepted start.
- R10: A `start_i` pulse during a read is ignored. Changes to `addr_i`, `big_part_i` or `div_i` during a read do not affect that read, and no second read follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to start a read |
| big_part_i | input | 1 | 1 selects the 8-bit address part, 0 the 6-bit part |
| addr_i | input | 8 | Word address |
| div_i | input | 8 | Phase length minus one, in system clocks |
| done_o | output | 1 | One-cycle pulse when `data_o` holds the new word |
| data_o | output | 16 | Word read from the EEPROM |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_mosi_o | output | 1 | Serial data to the EEPROM |
| ee_miso_i | input | 1 | Serial data from the EEPROM |

## Verification
The hardest case to reach from the ports is a read that is disturbed while it runs. A second start arrives, and the address, part select and divider all change in the middle of the sequence. The read must still finish with the original length, address and data, and no second frame may follow. The bench reaches this case by raising `start_i` again some twenty cycles into a read, at the same time as it changes every input. It also pulls reset during a frame. A behavioural EEPROM model in the bench decodes the start bit, opcode and address at each rising serial clock edge. It drives a dummy zero and then the data bits. It also counts the framing pulses and measures each high phase. If the block sampled one phase too early, it would catch the dummy zero, and the random data words would expose that.

// File: rtl/uwr_pkg.sv
`timescale 1ns/1ps
package uwr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CS_UP, ST_LEAD_HI, ST_LEAD_LO,
    ST_BIT_SET, ST_BIT_HI, ST_BIT_LO,
    ST_DAT_SET, ST_DAT_HI, ST_DAT_LO,
    ST_CS_DN, ST_TAIL_HI, ST_TAIL_LO
  } uwr_state_e;

  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] READ_CMD = 3'b110;
endpackage

// File: rtl/uwr_phase_timer.sv
`timescale 1ns/1ps
module uwr_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             end_o
);
  logic [DIV_W-1:0] div_q, div_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;

  assign end_o = run_i && (cnt_q == div_q);

  always_comb begin
    div_n = div_q;
    if (load_i) div_n = div_i;
    if (load_i || !run_i || end_o) cnt_n = '0;
    else                           cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_n;
      cnt_q <= cnt_n;
    end
  end

  AST_PHASE_END_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (end_o && div_q != '0) |=> !end_o); // R2
endmodule

// File: rtl/uwr_tx_shift.sv
`timescale 1ns/1ps
module uwr_tx_shift import uwr_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int SMALL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              big_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int TX_W  = CMD_W + ADDR_W;
  localparam int CNT_W = $clog2(TX_W + 1);

  logic [TX_W-1:0]  sr_q, sr_n, load_val;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  generate
    if (ADDR_W > SMALL_W) begin : g_pad
      always_comb load_val = big_i ? {READ_CMD, addr_i}
                                   : {READ_CMD, addr_i[SMALL_W-1:0], {(ADDR_W-SMALL_W){1'b0}}};
    end else begin : g_nopad
      always_comb load_val = {READ_CMD, addr_i};
    end
  endgenerate

  assign bit_o  = sr_q[TX_W-1];
  assign last_o = (cnt_q == CNT_W'(1));

  always_comb begin
    sr_n  = sr_q;
    cnt_n = cnt_q;
    if (load_i) begin
      sr_n  = load_val;
      cnt_n = big_i ? CNT_W'(TX_W) : CNT_W'(CMD_W + SMALL_W);
    end else if (shift_i) begin
      sr_n  = {sr_q[TX_W-2:0], 1'b0};
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_n;
      cnt_q <= cnt_n;
    end
  end

  AST_TX_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> cnt_q != '0); // R5
endmodule

// File: rtl/uwr_rx_shift.sv
`timescale 1ns/1ps
module uwr_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o,
  output logic              last_o
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] word_q, word_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  assign word_o = word_q;
  assign last_o = (cnt_q == CNT_W'(DATA_W - 1));

  always_comb begin
    word_n = word_q;
    cnt_n  = cnt_q;
    if (clr_i) begin
      cnt_n = '0;
    end else if (sample_i) begin
      word_n = {word_q[DATA_W-2:0], bit_i};
      cnt_n  = last_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/uwire_word_reader.sv
`timescale 1ns/1ps
module uwire_word_reader import uwr_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int SMALL_W = 6,
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              big_part_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_mosi_o,
  input  logic              ee_miso_i
);
  uwr_state_e state_q, state_n;
  logic accept, adv, tx_bit, tx_last, rx_last, tx_shift, rx_sample;
  logic done_q, done_n;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign tx_shift  = (state_q == ST_BIT_LO) && adv;
  assign rx_sample = (state_q == ST_DAT_LO) && adv;

  uwr_phase_timer #(.DIV_W(DIV_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .div_i(div_i),
    .run_i(state_q != ST_IDLE), .end_o(adv));

  uwr_tx_shift #(.ADDR_W(ADDR_W), .SMALL_W(SMALL_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .big_i(big_part_i),
    .addr_i(addr_i), .shift_i(tx_shift), .bit_o(tx_bit), .last_o(tx_last));

  uwr_rx_shift #(.DATA_W(DATA_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .clr_i(accept), .sample_i(rx_sample),
    .bit_i(ee_miso_i), .word_o(data_o), .last_o(rx_last));

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE:    if (accept) state_n = ST_CS_UP;
      ST_CS_UP:   if (adv) state_n = ST_LEAD_HI;
      ST_LEAD_HI: if (adv) state_n = ST_LEAD_LO;
      ST_LEAD_LO: if (adv) state_n = ST_BIT_SET;
      ST_BIT_SET: if (adv) state_n = ST_BIT_HI;
      ST_BIT_HI:  if (adv) state_n = ST_BIT_LO;
      ST_BIT_LO:  if (adv) state_n = tx_last ? ST_DAT_SET : ST_BIT_SET;
      ST_DAT_SET: if (adv) state_n = ST_DAT_HI;
      ST_DAT_HI:  if (adv) state_n = ST_DAT_LO;
      ST_DAT_LO:  if (adv) state_n = rx_last ? ST_CS_DN : ST_DAT_HI;
      ST_CS_DN:   if (adv) state_n = ST_TAIL_HI;
      ST_TAIL_HI: if (adv) state_n = ST_TAIL_LO;
      ST_TAIL_LO: if (adv) state_n = ST_IDLE;
      default:    state_n = ST_IDLE;
    endcase
    done_n = (state_q == ST_TAIL_LO) && adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
    end
  end

  assign done_o = done_q;

  always_comb begin
    ee_cs_o   = 1'b0;
    ee_sk_o   = 1'b0;
    ee_mosi_o = 1'b0;
    case (state_q)
      ST_CS_UP, ST_LEAD_LO, ST_DAT_SET, ST_DAT_LO: ee_cs_o = 1'b1;
      ST_LEAD_HI, ST_DAT_HI: begin ee_cs_o = 1'b1; ee_sk_o = 1'b1; end
      ST_BIT_SET, ST_BIT_LO: begin ee_cs_o = 1'b1; ee_mosi_o = tx_bit; end
      ST_BIT_HI: begin ee_cs_o = 1'b1; ee_sk_o = 1'b1; ee_mosi_o = tx_bit; end
      ST_TAIL_HI: ee_sk_o = 1'b1;
      default: ;
    endcase
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> $stable(data_o)); // R9
  AST_PIN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !adv) |=> $stable({ee_cs_o, ee_sk_o, ee_mosi_o})); // R2
  AST_CS_DROP_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs_o) |-> !ee_sk_o); // R8
endmodule

// File: tb/uwire_word_reader_tb_top.sv
`timescale 1ns/1ps
module uwire_word_reader_tb_top;
  logic clk = 1'b0;
  logic rst_n, start_i, big_part_i, ee_miso_i;
  logic [7:0] addr_i, div_i;
  logic done_o, ee_cs_o, ee_sk_o, ee_mosi_o;
  logic [15:0] data_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uwire_word_reader dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .big_part_i(big_part_i),
    .addr_i(addr_i), .div_i(div_i), .done_o(done_o), .data_o(data_o),
    .ee_cs_o(ee_cs_o), .ee_sk_o(ee_sk_o), .ee_mosi_o(ee_mosi_o),
    .ee_miso_i(ee_miso_i));

  function automatic logic [15:0] memf(input logic [7:0] a);
    logic [15:0] p;
    p = 16'({8'd0, a} * 16'd40503);
    return p ^ 16'h5AC3 ^ {a, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural EEPROM model, evaluated away from the active edge
  int m_st, m_cnt, m_alen, m_idx, pre_edges, data_edges, tail_edges, mosi_bad;
  int hi_run, hi_bad, m_div;
  logic [1:0] m_op;
  logic [7:0] m_addr;
  logic [15:0] m_word;
  logic prev_sk = 1'b0, prev_cs = 1'b0, m_inframe = 1'b0;

  always @(negedge clk) begin
    if (ee_cs_o && !prev_cs) m_inframe = 1'b1;
    if (ee_sk_o) hi_run++;
    if (!ee_sk_o && prev_sk) begin
      if (hi_run != m_div + 1) hi_bad++;
      hi_run = 0;
    end
    if (ee_sk_o && !prev_sk) begin
      if (!ee_cs_o) begin
        if (m_inframe) tail_edges++;
      end else begin
        case (m_st)
          0: if (ee_mosi_o) begin m_st = 1; m_cnt = 0; end else pre_edges++;
          1: begin
            m_op = {m_op[0], ee_mosi_o}; m_cnt++;
            if (m_cnt == 2) begin m_st = 2; m_cnt = 0; end
          end
          2: begin
            m_addr = {m_addr[6:0], ee_mosi_o}; m_cnt++;
            if (m_cnt == m_alen) begin
              m_st = 3; ee_miso_i = 1'b0; m_word = memf(m_addr); m_idx = 15;
            end
          end
          default: begin
            data_edges++;
            if (ee_mosi_o) mosi_bad++;
            if (m_idx >= 0) ee_miso_i = m_word[m_idx];
            m_idx--;
          end
        endcase
      end
    end
    prev_sk = ee_sk_o;
    prev_cs = ee_cs_o;
  end

  task automatic model_clear(input int alen, input int dv);
    m_st = 0; m_cnt = 0; m_alen = alen; m_idx = 15; m_div = dv;
    pre_edges = 0; data_edges = 0; tail_edges = 0; mosi_bad = 0;
    hi_run = 0; hi_bad = 0; m_op = '0; m_addr = '0; m_inframe = 1'b0;
    ee_miso_i = 1'b0;
  endtask

  task automatic run_txn(input logic big, input logic [7:0] addr,
                         input int dv, input bit poke);
    int alen, cyc, exp_len;
    logic [7:0] exp_addr;
    logic [15:0] held;
    alen = big ? 8 : 6;
    exp_addr = big ? addr : (addr & 8'h3F);
    exp_len = (48 + 3 * alen) * (dv + 1);
    model_clear(alen, dv);
    big_part_i = big; addr_i = addr; div_i = 8'(dv); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 20) begin
        start_i = 1'b1; big_part_i = ~big; addr_i = ~addr; div_i = 8'(dv + 3);
      end else if (poke && cyc == 21) begin
        start_i = 1'b0;
      end
    end
    chk(cyc == exp_len, "R2", "frame length", cyc, exp_len);
    chk(hi_bad == 0, "R2", "sk high phase length", hi_bad, 0);
    chk(pre_edges == 1, "R3", "framing pulses before command", pre_edges, 1);
    chk(m_op == 2'b10, "R4", "opcode after start bit", m_op, 2'b10);
    chk(m_addr == exp_addr, "R5", "address received", m_addr, exp_addr);
    chk(data_edges == 16 && mosi_bad == 0, "R6", "data pulses / mosi high",
        {data_edges[15:0], mosi_bad[15:0]}, {16'd16, 16'd0});
    chk(data_o == memf(exp_addr), "R7", "data word", data_o, memf(exp_addr));
    chk(tail_edges == 1 && !ee_cs_o, "R8", "closing pulses", tail_edges, 1);
    held = data_o;
    @(negedge clk);
    chk(!done_o, "R9", "done width", done_o, 0);
    repeat (5) @(negedge clk);
    chk(data_o == held && !done_o, "R9", "data held", data_o, held);
    if (poke)
      chk(!ee_cs_o && tail_edges == 1, "R10", "no second frame after busy start",
          ee_cs_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; big_part_i = 1'b0; addr_i = '0; div_i = '0;
    model_clear(6, 0);
    repeat (3) @(negedge clk);
    chk({ee_cs_o, ee_sk_o, ee_mosi_o, done_o} == 4'b0 && data_o == 16'h0,
        "R1", "reset state", {ee_cs_o, ee_sk_o, ee_mosi_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_txn(1'b1, 8'hA5, 2, 1'b0);
    run_txn(1'b0, 8'hFF, 0, 1'b0);   // R5 upper bits ignored
    run_txn(1'b1, 8'h00, 0, 1'b0);
    run_txn(1'b0, 8'hC0, 3, 1'b0);   // R5 maps to address 0
    run_txn(1'b1, 8'hFF, 1, 1'b0);
    run_txn(1'b1, 8'h3C, 1, 1'b1);   // R10 busy start and input changes
    run_txn(1'b0, 8'h15, 0, 1'b1);   // R10

    // R1 reset in mid-frame
    model_clear(8, 1);
    big_part_i = 1'b1; addr_i = 8'h77; div_i = 8'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({ee_cs_o, ee_sk_o, ee_mosi_o, done_o} == 4'b0, "R1", "mid-frame reset pins",
        {ee_cs_o, ee_sk_o, ee_mosi_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ee_cs_o, "R1", "idle after reset", ee_cs_o, 0);

    for (int i = 0; i < 40; i++) begin
      run_txn(1'($urandom % 2), 8'($urandom), int'($urandom % 4),
              ($urandom % 5) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule